// File: doc/BRIEF.md
# Host Descriptor Ring Fetch Engine

This block lets a device pull its own transmit work out of host memory. Each of its queues owns a ring of 16-byte descriptors in host memory. Software programs a ring's base address and size, enables the queue, and then rings a doorbell that carries the new producer index. Whenever a queue holds unconsumed descriptors, the engine reads the descriptor at the consumer slot. It decodes the buffer address and byte length from the returned completion, and then reads that buffer.

Only one descriptor is handled at a time. The next queue is picked round-robin among the queues with work pending. The consumer index moves on once the buffer read completes, or at once for a zero-length descriptor. Requests leave on a valid/ready channel that carries address, length and a kind bit. Completions come back as a single-cycle pulse that carries the 16 descriptor bytes. Read ports show the producer index, the consumer index and the sticky error flags of each queue.

Top module: `desc_fetch_engine`

## Requirements
- R1: After reset every queue is disabled, every producer and consumer index is zero, every error flag is clear and no request is valid.
- R2: Register field codes are 0 base address, 1 ring size (log2 in data bits [3:0]), 2 doorbell (producer index in data bits [15:0]) and 3 enable (data bit 0). Base and size writes take effect only while the queue is disabled. A size write also zeroes that queue's indices and clears its error flag.
- R3: A doorbell value is accepted only if it is below 2·size and (value − consumer) mod 2·size is at most size. Otherwise the producer index keeps its value and the queue's error flag is set and stays set.
- R4: A queue has work only while it is enabled and its producer index differs from its consumer index. A disabled queue is never fetched.
- R5: A descriptor request has kind 0, length 16 and address base + (consumer mod size)·16.
- R6: A buffer request has kind 1 and is raised only after the descriptor completion. Its address is completion bits [63:0] and its length is completion bits [95:64].
- R7: A descriptor whose length field is zero produces no buffer request and is still consumed.
- R8: The consumer index advances by one, modulo 2·size, when a descriptor is finished.
- R9: At most one request is outstanding. A valid request keeps its address, length and kind until it is accepted.
- R10: After finishing a descriptor, the engine serves the next queue with work in ascending index order, wrapping around. Queue 0 has the first turn after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_queue | input | 2 | Queue addressed by the write |
| reg_wr_field | input | 2 | Field code of the write |
| reg_wr_data | input | 64 | Write data |
| rd_queue | input | 2 | Queue shown on the read ports |
| rd_prod_idx | output | 16 | Producer index of the selected queue |
| rd_cons_idx | output | 16 | Consumer index of the selected queue |
| err_flags | output | 4 | Sticky doorbell error flag per queue |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Host byte address of the read |
| req_len | output | 32 | Byte length of the read |
| req_kind | output | 1 | 0 descriptor read, 1 buffer read |
| cpl_valid | input | 1 | Completion of the outstanding read |
| cpl_data | input | 128 | Descriptor bytes on a descriptor completion |

## Verification
The bench aims at the ring wrap: a queue is filled to exactly its size, and its slots must come out as 2, 3, 0 and 1. An index that wrapped at the ring size instead of twice the size would either reject that doorbell or produce wrong slot addresses. Overfull and out-of-range doorbells are written to both an enabled queue and a disabled one. A bad occupancy test would move the producer index and start fetches on stale slots. Base and size writes to an enabled queue must not shift any descriptor address, and a zero-length descriptor must not raise a buffer read. If round-robin is wrong, queues are served out of turn. If a disabled queue is treated as having work, a request appears while everything should be idle.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    typedef enum logic [1:0] {
        FLD_BASE     = 2'd0,
        FLD_SIZE     = 2'd1,
        FLD_DOORBELL = 2'd2,
        FLD_ENABLE   = 2'd3
    } dfe_field_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DESC_REQ  = 3'd1,
        ST_DESC_WAIT = 3'd2,
        ST_DATA_REQ  = 3'd3,
        ST_DATA_WAIT = 3'd4
    } dfe_state_e;

    localparam int DESC_BYTES   = 16;
    localparam int DESC_SHIFT   = 4;
    localparam int DESC_BITS    = DESC_BYTES * 8;
    localparam int DESC_LEN_LSB = 64;

endpackage

// File: rtl/dfe_queue_regs.sv
module dfe_queue_regs
    import dfe_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 64,
    parameter int IW = 16,
    localparam int QW  = $clog2(NQ),
    localparam int LGW = $clog2(IW)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [QW-1:0]           wr_q,
    input  logic [1:0]              wr_field,
    input  logic [AW-1:0]           wr_data,
    input  logic                    adv_valid,
    input  logic [QW-1:0]           adv_q,
    output logic [NQ-1:0][AW-1:0]   base_o,
    output logic [NQ-1:0][LGW-1:0]  lg_o,
    output logic [NQ-1:0][IW-1:0]   pi_o,
    output logic [NQ-1:0][IW-1:0]   ci_o,
    output logic [NQ-1:0]           pending_o,
    output logic [NQ-1:0]           err_o
);

    typedef struct packed {
        logic [AW-1:0]  base;
        logic [LGW-1:0] lg;
        logic [IW-1:0]  pi;
        logic [IW-1:0]  ci;
        logic           en;
        logic           err;
    } qstate_t;

    qstate_t q_d [NQ];
    qstate_t q_q [NQ];

    function automatic logic [IW:0] span_f(input logic [LGW-1:0] lg);
        logic [IW:0] one;
        one = (IW+1)'(1);
        return one << ({1'b0, lg} + (LGW+1)'(1));
    endfunction

    function automatic logic [IW:0] size_f(input logic [LGW-1:0] lg);
        logic [IW:0] one;
        one = (IW+1)'(1);
        return one << lg;
    endfunction

    function automatic logic [IW-1:0] wrap_mask_f(input logic [LGW-1:0] lg);
        return IW'(span_f(lg) - (IW+1)'(1));
    endfunction

    function automatic logic db_ok_f(input logic [IW-1:0] new_pi,
                                     input logic [IW-1:0] ci,
                                     input logic [LGW-1:0] lg);
        logic [IW-1:0] occ;
        occ = (new_pi - ci) & wrap_mask_f(lg);
        return ({1'b0, new_pi} < span_f(lg)) && ({1'b0, occ} <= size_f(lg));
    endfunction

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            q_d[i] = q_q[i];
            if (adv_valid && adv_q == QW'(i)) begin
                q_d[i].ci = (q_q[i].ci + IW'(1)) & wrap_mask_f(q_q[i].lg);
            end
            if (wr_en && wr_q == QW'(i)) begin
                case (dfe_field_e'(wr_field))
                    FLD_BASE: begin
                        if (!q_q[i].en) q_d[i].base = wr_data;
                    end
                    FLD_SIZE: begin
                        if (!q_q[i].en) begin
                            q_d[i].lg  = wr_data[LGW-1:0];
                            q_d[i].pi  = '0;
                            q_d[i].ci  = '0;
                            q_d[i].err = 1'b0;
                        end
                    end
                    FLD_DOORBELL: begin
                        if (db_ok_f(wr_data[IW-1:0], q_q[i].ci, q_q[i].lg)) begin
                            q_d[i].pi = wr_data[IW-1:0];
                        end else begin
                            q_d[i].err = 1'b1;
                        end
                    end
                    default: q_d[i].en = wr_data[0];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NQ; i++) begin
            if (rst) q_q[i] <= '0;
            else     q_q[i] <= q_d[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            base_o[i]    = q_q[i].base;
            lg_o[i]      = q_q[i].lg;
            pi_o[i]      = q_q[i].pi;
            ci_o[i]      = q_q[i].ci;
            err_o[i]     = q_q[i].err;
            pending_o[i] = q_q[i].en && (q_q[i].pi != q_q[i].ci);
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        // R3
        err_only_on_bad_db_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(err_o[g]) |-> $past(wr_en && wr_q == QW'(g) && wr_field == FLD_DOORBELL));
        // R8
        ci_moves_on_adv_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(ci_o[g]) |->
                $past((adv_valid && adv_q == QW'(g)) ||
                      (wr_en && wr_q == QW'(g) && wr_field == FLD_SIZE)));
    end

endmodule

// File: rtl/dfe_rr_arb.sv
module dfe_rr_arb #(
    parameter int NQ = 4,
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] pending_i,
    input  logic          adv_valid,
    input  logic [QW-1:0] adv_q,
    output logic          gnt_valid,
    output logic [QW-1:0] gnt_idx
);

    logic [QW-1:0] last_d, last_q;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = NQ; k >= 1; k--) begin
            if (pending_i[(int'(last_q) + k) % NQ]) begin
                gnt_valid = 1'b1;
                gnt_idx   = QW'((int'(last_q) + k) % NQ);
            end
        end
        last_d = adv_valid ? adv_q : last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= QW'(NQ - 1);
        else     last_q <= last_d;
    end

    // R10
    gnt_is_pending_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> pending_i[gnt_idx]);

endmodule

// File: rtl/dfe_fetch_fsm.sv
module dfe_fetch_fsm
    import dfe_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 64,
    parameter int IW = 16,
    parameter int LW = 32,
    localparam int QW  = $clog2(NQ),
    localparam int LGW = $clog2(IW)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    gnt_valid,
    input  logic [QW-1:0]           gnt_idx,
    input  logic [NQ-1:0][AW-1:0]   base_i,
    input  logic [NQ-1:0][LGW-1:0]  lg_i,
    input  logic [NQ-1:0][IW-1:0]   ci_i,
    input  logic                    req_ready,
    input  logic                    cpl_valid,
    input  logic [DESC_BITS-1:0]    cpl_data,
    output logic                    req_valid,
    output logic [AW-1:0]           req_addr,
    output logic [LW-1:0]           req_len,
    output logic                    req_kind,
    output logic                    adv_valid,
    output logic [QW-1:0]           adv_q
);

    typedef struct packed {
        dfe_state_e     st;
        logic [QW-1:0]  q;
        logic [AW-1:0]  addr;
        logic [LW-1:0]  len;
        logic           kind;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [IW-1:0] slot;
    logic [AW-1:0] buf_addr;
    logic [LW-1:0] buf_len;

    always_comb begin
        s_d       = s_q;
        adv_valid = 1'b0;
        adv_q     = s_q.q;
        slot      = ci_i[gnt_idx] & ((IW'(1) << lg_i[gnt_idx]) - IW'(1));
        buf_addr  = cpl_data[AW-1:0];
        buf_len   = cpl_data[DESC_LEN_LSB +: LW];
        case (s_q.st)
            ST_IDLE: begin
                if (gnt_valid) begin
                    s_d.q    = gnt_idx;
                    s_d.addr = base_i[gnt_idx] + (AW'(slot) << DESC_SHIFT);
                    s_d.len  = LW'(DESC_BYTES);
                    s_d.kind = 1'b0;
                    s_d.st   = ST_DESC_REQ;
                end
            end
            ST_DESC_REQ: begin
                if (req_ready) s_d.st = ST_DESC_WAIT;
            end
            ST_DESC_WAIT: begin
                if (cpl_valid) begin
                    if (buf_len == '0) begin
                        adv_valid = 1'b1;
                        s_d.st    = ST_IDLE;
                    end else begin
                        s_d.addr = buf_addr;
                        s_d.len  = buf_len;
                        s_d.kind = 1'b1;
                        s_d.st   = ST_DATA_REQ;
                    end
                end
            end
            ST_DATA_REQ: begin
                if (req_ready) s_d.st = ST_DATA_WAIT;
            end
            ST_DATA_WAIT: begin
                if (cpl_valid) begin
                    adv_valid = 1'b1;
                    s_d.st    = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{st: ST_IDLE, default: '0};
        else     s_q <= s_d;
    end

    assign req_valid = (s_q.st == ST_DESC_REQ) || (s_q.st == ST_DATA_REQ);
    assign req_addr  = s_q.addr;
    assign req_len   = s_q.len;
    assign req_kind  = s_q.kind;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=>
            req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_kind));
    // R6
    data_after_cpl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid && req_kind) |-> $past(cpl_valid));
    // R5
    desc_len_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_kind |-> req_len == LW'(DESC_BYTES));

endmodule

// File: rtl/desc_fetch_engine.sv
module desc_fetch_engine
    import dfe_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 64,
    parameter int IW = 16,
    parameter int LW = 32,
    localparam int QW  = $clog2(NQ),
    localparam int LGW = $clog2(IW)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [QW-1:0]        reg_wr_queue,
    input  logic [1:0]           reg_wr_field,
    input  logic [AW-1:0]        reg_wr_data,
    input  logic [QW-1:0]        rd_queue,
    output logic [IW-1:0]        rd_prod_idx,
    output logic [IW-1:0]        rd_cons_idx,
    output logic [NQ-1:0]        err_flags,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [AW-1:0]        req_addr,
    output logic [LW-1:0]        req_len,
    output logic                 req_kind,
    input  logic                 cpl_valid,
    input  logic [DESC_BITS-1:0] cpl_data
);

    logic [NQ-1:0][AW-1:0]  base_w;
    logic [NQ-1:0][LGW-1:0] lg_w;
    logic [NQ-1:0][IW-1:0]  pi_w;
    logic [NQ-1:0][IW-1:0]  ci_w;
    logic [NQ-1:0]          pending_w;
    logic                   adv_valid_w;
    logic [QW-1:0]          adv_q_w;
    logic                   gnt_valid_w;
    logic [QW-1:0]          gnt_idx_w;

    dfe_queue_regs #(.NQ(NQ), .AW(AW), .IW(IW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_q      (reg_wr_queue),
        .wr_field  (reg_wr_field),
        .wr_data   (reg_wr_data),
        .adv_valid (adv_valid_w),
        .adv_q     (adv_q_w),
        .base_o    (base_w),
        .lg_o      (lg_w),
        .pi_o      (pi_w),
        .ci_o      (ci_w),
        .pending_o (pending_w),
        .err_o     (err_flags)
    );

    dfe_rr_arb #(.NQ(NQ)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .pending_i (pending_w),
        .adv_valid (adv_valid_w),
        .adv_q     (adv_q_w),
        .gnt_valid (gnt_valid_w),
        .gnt_idx   (gnt_idx_w)
    );

    dfe_fetch_fsm #(.NQ(NQ), .AW(AW), .IW(IW), .LW(LW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .gnt_valid (gnt_valid_w),
        .gnt_idx   (gnt_idx_w),
        .base_i    (base_w),
        .lg_i      (lg_w),
        .ci_i      (ci_w),
        .req_ready (req_ready),
        .cpl_valid (cpl_valid),
        .cpl_data  (cpl_data),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_kind  (req_kind),
        .adv_valid (adv_valid_w),
        .adv_q     (adv_q_w)
    );

    assign rd_prod_idx = pi_w[rd_queue];
    assign rd_cons_idx = ci_w[rd_queue];

    // R4
    fetch_needs_work_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) && !req_kind |-> $past(|pending_w));

endmodule

// File: tb/desc_fetch_engine_test.sv
module desc_fetch_engine_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_wr_queue = '0;
    logic [1:0]   reg_wr_field = '0;
    logic [63:0]  reg_wr_data = '0;
    logic [1:0]   rd_queue = '0;
    logic [15:0]  rd_prod_idx;
    logic [15:0]  rd_cons_idx;
    logic [3:0]   err_flags;
    logic         req_valid;
    logic         req_ready = 1'b0;
    logic [63:0]  req_addr;
    logic [31:0]  req_len;
    logic         req_kind;
    logic         cpl_valid = 1'b0;
    logic [127:0] cpl_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    desc_fetch_engine uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_queue(reg_wr_queue),
        .reg_wr_field(reg_wr_field), .reg_wr_data(reg_wr_data),
        .rd_queue(rd_queue), .rd_prod_idx(rd_prod_idx), .rd_cons_idx(rd_cons_idx),
        .err_flags(err_flags),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_kind(req_kind),
        .cpl_valid(cpl_valid), .cpl_data(cpl_data)
    );

    // {queue, descriptor address, buffer address, buffer length}
    localparam logic [167:0] VEC [0:3] = '{
        {8'd0, 64'h1000, 64'h0000_A000, 32'd64},
        {8'd1, 64'h2000, 64'h0000_B000, 32'd128},
        {8'd2, 64'h3000, 64'h0000_0000, 32'd0},
        {8'd0, 64'h1010, 64'h0000_A100, 32'd32}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int q, input int f, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en    = 1'b1;
        reg_wr_queue = 2'(q);
        reg_wr_field = 2'(f);
        reg_wr_data  = d;
        @(negedge clk);
        reg_wr_en    = 1'b0;
    endtask

    task automatic peek(input int q);
        rd_queue = 2'(q);
        #1;
    endtask

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (req_valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic accept_and_complete(input logic [127:0] data);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        @(negedge clk);
        cpl_valid = 1'b1;
        cpl_data  = data;
        @(negedge clk);
        cpl_valid = 1'b0;
        cpl_data  = '0;
    endtask

    task automatic serve_desc(input logic [63:0] exp_addr, input logic [63:0] baddr,
                              input logic [31:0] blen, input string tag);
        bit got;
        logic [63:0] first_addr;
        wait_req(got);
        chk(got, {tag, " R5 descriptor request present"}, 64'(got), 64'd1);
        chk(req_kind == 1'b0, {tag, " R5 kind"}, 64'(req_kind), 64'd0);
        chk(req_addr == exp_addr, {tag, " R5/R10 descriptor address"}, req_addr, exp_addr);
        chk(req_len == 32'd16, {tag, " R5 length"}, 64'(req_len), 64'd16);
        first_addr = req_addr;
        @(negedge clk);
        chk(req_valid && req_addr == first_addr, {tag, " R9 request held"}, req_addr, first_addr);
        accept_and_complete({32'h0, blen, baddr});
    endtask

    task automatic serve_data(input logic [63:0] exp_addr, input logic [31:0] exp_len,
                              input string tag);
        bit got;
        wait_req(got);
        chk(got && req_kind == 1'b1, {tag, " R6 buffer request kind"}, 64'(req_kind), 64'd1);
        chk(req_addr == exp_addr, {tag, " R6 buffer address"}, req_addr, exp_addr);
        chk(req_len == exp_len, {tag, " R6 buffer length"}, 64'(req_len), 64'(exp_len));
        accept_and_complete('0);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !finished) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        peek(0);
        chk(req_valid == 1'b0, "R1 no request", 64'(req_valid), 64'd0);
        chk(err_flags == 4'h0, "R1 errors clear", 64'(err_flags), 64'd0);
        chk(rd_prod_idx == 16'd0 && rd_cons_idx == 16'd0, "R1 indices zero",
            64'({rd_prod_idx, rd_cons_idx}), 64'd0);
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R1 disabled queues idle", 64'(req_valid), 64'd0);

        // program queues: 0 size 4, 1 size 8, 2 size 4
        wr(0, 0, 64'h1000); wr(0, 1, 64'd2); wr(0, 3, 64'd1);
        wr(1, 0, 64'h2000); wr(1, 1, 64'd3); wr(1, 3, 64'd1);
        wr(2, 0, 64'h3000); wr(2, 1, 64'd2); wr(2, 3, 64'd1);
        // R2: base and size writes to an enabled queue are ignored
        wr(0, 0, 64'h9000);
        wr(0, 1, 64'd3);

        wr(0, 2, 64'd2);
        wr(1, 2, 64'd1);
        wr(2, 2, 64'd1);

        // table walk: R5 R6 R7 R10
        for (int v = 0; v < 4; v++) begin
            serve_desc(VEC[v][159:96], VEC[v][95:32], VEC[v][31:0], $sformatf("vec%0d", v));
            if (VEC[v][31:0] != 32'd0) begin
                serve_data(VEC[v][95:32], VEC[v][31:0], $sformatf("vec%0d", v));
            end else begin
                chk(!(req_valid && req_kind), "R7 zero length gives no buffer read",
                    64'(req_kind), 64'd0);
            end
        end

        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R4 all rings drained", 64'(req_valid), 64'd0);
        peek(0);
        chk(rd_cons_idx == 16'd2, "R8 queue 0 consumer", 64'(rd_cons_idx), 64'd2);
        peek(1);
        chk(rd_cons_idx == 16'd1, "R8 queue 1 consumer", 64'(rd_cons_idx), 64'd1);
        peek(2);
        chk(rd_cons_idx == 16'd1, "R7 zero length consumed", 64'(rd_cons_idx), 64'd1);

        // disabled queue 3: size 2, bad and good doorbells
        wr(3, 1, 64'd1);
        wr(3, 2, 64'd3);
        peek(3);
        chk(err_flags[3] == 1'b1, "R3 overfull doorbell flags error", 64'(err_flags), 64'h8);
        chk(rd_prod_idx == 16'd0, "R3 overfull doorbell ignored", 64'(rd_prod_idx), 64'd0);
        wr(3, 2, 64'd2);
        peek(3);
        chk(rd_prod_idx == 16'd2, "R3 full ring doorbell accepted", 64'(rd_prod_idx), 64'd2);
        chk(err_flags[3] == 1'b1, "R3 error sticky", 64'(err_flags[3]), 64'd1);
        repeat (10) @(negedge clk);
        chk(req_valid == 1'b0, "R4 disabled queue not fetched", 64'(req_valid), 64'd0);
        wr(3, 1, 64'd1);
        peek(3);
        chk(rd_prod_idx == 16'd0 && err_flags[3] == 1'b0, "R2 size write resets queue",
            64'({rd_prod_idx, 3'b0, err_flags[3]}), 64'd0);

        // wraparound on queue 0: ci 2, fill to exactly size 4
        wr(0, 2, 64'd6);
        serve_desc(64'h1020, 64'h0, 32'd0, "wrap slot2");
        serve_desc(64'h1030, 64'h0, 32'd0, "wrap slot3");
        serve_desc(64'h1000, 64'h0, 32'd0, "wrap slot0");
        serve_desc(64'h1010, 64'h0, 32'd0, "wrap slot1");
        repeat (3) @(negedge clk);
        peek(0);
        chk(rd_cons_idx == 16'd6, "R8 consumer wraps modulo twice size", 64'(rd_cons_idx), 64'd6);
        chk(err_flags[0] == 1'b0, "R3 full doorbell no error", 64'(err_flags[0]), 64'd0);

        // overfull doorbell on enabled queue 0: (3-6) mod 8 = 5 > 4
        wr(0, 2, 64'd3);
        peek(0);
        chk(rd_prod_idx == 16'd6, "R3 enabled overfull ignored", 64'(rd_prod_idx), 64'd6);
        chk(err_flags[0] == 1'b1, "R3 enabled overfull flags error", 64'(err_flags[0]), 64'd1);
        // out of range value 8 >= 2*size
        wr(0, 2, 64'd8);
        peek(0);
        chk(rd_prod_idx == 16'd6, "R3 out of range ignored", 64'(rd_prod_idx), 64'd6);
        repeat (4) @(negedge clk);
        chk(req_valid == 1'b0, "R4 no fetch after rejected doorbells", 64'(req_valid), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule